// File: doc/BRIEF.md
# Interleaved Cache-Line Refill Memory

This block answers cache-line refill requests from a set of on-chip storage banks that sit behind one shared 32-bit return bus. A line is four 32-bit words, and word k of every line lives in bank k. Address bits [3:2] select the bank and bits [1:0] are the byte offset. A requester presents a line address with a valid/ready handshake. The block spends one cycle sending the address to the banks. Each bank then needs 25 cycles to reach its word. The four words come back on the bus in ascending bank order, and a done flag marks the last word.

Two access schemes can be chosen for each request with a mode input. In the interleaved scheme all four banks start in the same cycle, so the words leave on four consecutive cycles and a refill takes 30 cycles. In the sequential scheme the banks are accessed one after another, as a single word-wide memory would be, and a refill takes 102 cycles. After each refill the block reports how many cycles it took, so the two schemes can be compared exactly. The bank contents are loaded through a simple write port.

Top module: `refill_mem`

## Requirements
- R1: After reset, req_ready is 1, rd_valid and rd_last are 0, and refill_cycles is 0.
- R2: In interleaved mode (mode_seq = 0 when the request is accepted), the four words appear with rd_valid high in cycles 27, 28, 29 and 30, counted from the accepting clock edge. The accepting edge is edge 0, and cycle n ends at edge n.
- R3: In sequential mode (mode_seq = 1 when the request is accepted), the words appear in cycles 27, 52, 77 and 102, each alone, with rd_valid low between them.
- R4: The words come out in the order bank 0, 1, 2, 3. Word k is the content of bank k at row req_addr[7:4]. Bits [3:0] of req_addr have no effect on the data.
- R5: rd_last is high exactly with the fourth word and at no other time.
- R6: req_ready is low from the accepting edge until the fourth word has been delivered. A request made while req_ready is low is not taken. req_ready is 1 again in the cycle after the fourth word.
- R7: From the cycle after the fourth word, refill_cycles holds the length of that refill: 30 in interleaved mode and 102 in sequential mode.
- R8: Changing mode_seq while a refill is in progress has no effect on that refill.
- R9: When load_en is high at a clock edge, load_data is written into bank load_bank at row load_row. Later refills of that row return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_seq | input | 1 | 1 selects the sequential scheme, 0 the interleaved scheme; sampled at acceptance |
| req_valid | input | 1 | A refill request is present |
| req_addr | input | 32 | Byte address of the line to refill |
| req_ready | output | 1 | The block is idle and will accept a request |
| rd_valid | output | 1 | rd_data carries a word of the line |
| rd_data | output | 32 | Returned word |
| rd_last | output | 1 | Done flag, high with the fourth word |
| refill_cycles | output | 16 | Cycle count of the most recent refill |
| load_en | input | 1 | Write strobe for bank loading |
| load_bank | input | 2 | Bank to write |
| load_row | input | 4 | Row to write |
| load_data | input | 32 | Word to write |

## Verification
A wrong phase or timer in the controller or in a bank would move a word away from its expected cycle. Because every word is timed against the accepting edge, the fault shows at the first word, 27 cycles after the request, or at a later word in sequential mode. A wrong word pointer or row latch shows as a wrong rd_data value or order within the same refill. A corrupted cycle counter shows in refill_cycles one cycle after the done flag. Back-pressure faults show while the refill is still running, as a high req_ready or as a second request being accepted.

// File: rtl/refill_pkg.sv
`timescale 1ns/1ps
package refill_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WAIT,
        PH_EMIT
    } phase_e;

    // total refill length when all banks start together
    function automatic int interleaved_total(input int nb, input int acc);
        return 1 + acc + (nb - 1) + 1;
    endfunction

    // total refill length when banks are accessed one after another
    function automatic int sequential_total(input int nb, input int acc);
        return 1 + nb * acc + 1;
    endfunction

endpackage

// File: rtl/refill_bank.sv
`timescale 1ns/1ps
module refill_bank #(
    parameter int WORD_W  = 32,
    parameter int LINES   = 16,
    parameter int ACC_CYC = 25
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(LINES)-1:0]    wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        start,
    input  logic [$clog2(LINES)-1:0]    rd_idx,
    output logic                        fin,
    output logic [WORD_W-1:0]           rd_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TMR_W = $clog2(ACC_CYC + 1);

    typedef struct packed {
        logic [TMR_W-1:0]  tmr;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } bank_st_t;

    bank_st_t s_d, s_q;
    logic [WORD_W-1:0] cells [LINES];

    // storage array, written only through the load port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // access timer: a start loads the full latency, the word is captured
    // at the end of the last access cycle and held until the next start
    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.tmr = TMR_W'(ACC_CYC);
            s_d.idx = rd_idx;
        end else if (s_q.tmr != '0) begin
            s_d.tmr = s_q.tmr - 1'b1;
            if (s_q.tmr == TMR_W'(1)) begin
                s_d.data = cells[s_q.idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fin     = (s_q.tmr == TMR_W'(1));
    assign rd_data = s_q.data;

endmodule

// File: rtl/refill_ctrl.sv
`timescale 1ns/1ps
module refill_ctrl
    import refill_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32,
    parameter int NB     = 4,
    parameter int LINES  = 16,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      mode_seq,
    output logic                      req_ready,
    output logic [NB-1:0]             start,
    output logic [$clog2(LINES)-1:0]  line_idx,
    input  logic [NB-1:0]             fin,
    input  logic [WORD_W-1:0]         bank_data [NB],
    output logic                      rd_valid,
    output logic [WORD_W-1:0]         rd_data,
    output logic                      rd_last,
    output logic [CNT_W-1:0]          refill_cycles,
    output logic                      seq_mode
);

    localparam int IDX_W    = $clog2(LINES);
    localparam int BS_W     = $clog2(NB);
    localparam int OFF_W    = $clog2(WORD_W / 8);
    localparam int LINE_LSB = OFF_W + BS_W;

    typedef struct packed {
        phase_e            phase;
        logic [BS_W-1:0]   word;
        logic              seq;
        logic [IDX_W-1:0]  line;
        logic [CNT_W-1:0]  cyc;
        logic [CNT_W-1:0]  total;
    } ctrl_st_t;

    ctrl_st_t c_d, c_q;

    // byte offset, bank select and bits above the row index do not steer the refill
    logic unused_addr;
    assign unused_addr = ^req_addr;

    always_comb begin
        c_d       = c_q;
        start     = '0;
        req_ready = (c_q.phase == PH_IDLE);
        rd_valid  = 1'b0;
        rd_last   = 1'b0;
        rd_data   = bank_data[c_q.word];
        case (c_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    c_d.phase = PH_ADDR;
                    c_d.seq   = mode_seq;
                    c_d.line  = req_addr[LINE_LSB +: IDX_W];
                    c_d.word  = '0;
                    c_d.cyc   = CNT_W'(1);
                end
            end
            PH_ADDR: begin
                // address broadcast cycle: launch one bank or all of them
                start     = c_q.seq ? NB'(1) : '1;
                c_d.phase = PH_WAIT;
                c_d.cyc   = c_q.cyc + 1'b1;
            end
            PH_WAIT: begin
                c_d.cyc = c_q.cyc + 1'b1;
                if (fin[c_q.word]) begin
                    c_d.phase = PH_EMIT;
                    // chain the next bank so its access follows back to back
                    if (c_q.seq && (c_q.word != BS_W'(NB - 1))) begin
                        start[int'(c_q.word) + 1] = 1'b1;
                    end
                end
            end
            PH_EMIT: begin
                rd_valid = 1'b1;
                c_d.cyc  = c_q.cyc + 1'b1;
                if (c_q.word == BS_W'(NB - 1)) begin
                    rd_last   = 1'b1;
                    c_d.phase = PH_IDLE;
                    c_d.total = c_q.cyc;
                end else begin
                    c_d.word  = c_q.word + 1'b1;
                    c_d.phase = c_q.seq ? PH_WAIT : PH_EMIT;
                end
            end
            default: begin
                c_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign line_idx      = c_q.line;
    assign refill_cycles = c_q.total;
    assign seq_mode      = c_q.seq;

endmodule

// File: rtl/refill_mem.sv
`timescale 1ns/1ps
module refill_mem #(
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int NB      = 4,
    parameter int LINES   = 16,
    parameter int ACC_CYC = 25,
    parameter int CNT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_seq,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      req_ready,
    output logic                      rd_valid,
    output logic [WORD_W-1:0]         rd_data,
    output logic                      rd_last,
    output logic [CNT_W-1:0]          refill_cycles,
    input  logic                      load_en,
    input  logic [$clog2(NB)-1:0]     load_bank,
    input  logic [$clog2(LINES)-1:0]  load_row,
    input  logic [WORD_W-1:0]         load_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int BS_W  = $clog2(NB);

    logic [NB-1:0]     bank_start;
    logic [NB-1:0]     bank_fin;
    logic [WORD_W-1:0] bank_word [NB];
    logic [IDX_W-1:0]  line_idx;
    logic              seq_busy;

    refill_ctrl #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .NB     (NB),
        .LINES  (LINES),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .mode_seq      (mode_seq),
        .req_ready     (req_ready),
        .start         (bank_start),
        .line_idx      (line_idx),
        .fin           (bank_fin),
        .bank_data     (bank_word),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_last       (rd_last),
        .refill_cycles (refill_cycles),
        .seq_mode      (seq_busy)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic wr_sel;
        assign wr_sel = load_en && (load_bank == BS_W'(b));

        refill_bank #(
            .WORD_W  (WORD_W),
            .LINES   (LINES),
            .ACC_CYC (ACC_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel),
            .wr_idx  (load_row),
            .wr_data (load_data),
            .start   (bank_start[b]),
            .rd_idx  (line_idx),
            .fin     (bank_fin[b]),
            .rd_data (bank_word[b])
        );
    end

endmodule

// File: rtl/refill_mem_chk.sv
`timescale 1ns/1ps
module refill_mem_chk
    import refill_pkg::*;
#(
    parameter int NB      = 4,
    parameter int ACC_CYC = 25,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             rd_last,
    input logic [CNT_W-1:0] refill_cycles,
    input logic             seq_mode
);

    localparam logic [CNT_W-1:0] IL_TOTAL  = CNT_W'(interleaved_total(NB, ACC_CYC));
    localparam logic [CNT_W-1:0] SEQ_TOTAL = CNT_W'(sequential_total(NB, ACC_CYC));

    // R5
    last_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    // R6
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    drain_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last && !seq_mode) |=> rd_valid);

    // R3
    seq_words_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last && seq_mode) |=> !rd_valid);

    // R7
    refill_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> (refill_cycles == ($past(seq_mode) ? SEQ_TOTAL : IL_TOTAL)));

endmodule

bind refill_mem refill_mem_chk #(
    .NB      (NB),
    .ACC_CYC (ACC_CYC),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rd_valid      (rd_valid),
    .rd_last       (rd_last),
    .refill_cycles (refill_cycles),
    .seq_mode      (seq_busy)
);

// File: tb/refill_mem_bench.sv
`timescale 1ns/1ps
module refill_mem_bench;

    localparam int ACC = 25;
    localparam int NV  = 6;
    // bit 32 = mode (1 sequential), bits 31:0 = request address
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 32'h0000_0000},
        {1'b0, 32'h0000_01F0},
        {1'b1, 32'h0000_0030},
        {1'b0, 32'h0000_005B},
        {1'b1, 32'h0000_00E7},
        {1'b0, 32'h1234_567E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_seq = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_last;
    logic [15:0] refill_cycles;
    logic        load_en = 1'b0;
    logic [1:0]  load_bank = '0;
    logic [3:0]  load_row = '0;
    logic [31:0] load_data = '0;

    int  nvec = 0;
    int  nerr = 0;
    bit  finished = 1'b0;
    logic [31:0] shadow [4][16];

    always #10 clk = ~clk;

    refill_mem u_refill_mem (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_seq      (mode_seq),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_last       (rd_last),
        .refill_cycles (refill_cycles),
        .load_en       (load_en),
        .load_bank     (load_bank),
        .load_row      (load_row),
        .load_data     (load_data)
    );

    function automatic logic [31:0] pat(input int b, input int i);
        return {8'(i) ^ 8'h5A, 8'(b) ^ 8'hC3, 16'(i * 331 + b * 97 + 5)};
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic load_word(input int b, input int i, input logic [31:0] w);
        @(negedge clk);
        load_en   = 1'b1;
        load_bank = 2'(b);
        load_row  = 4'(i);
        load_data = w;
        shadow[b][i] = w;
    endtask

    task automatic do_refill(input logic [31:0] a, input logic m, input bit poke,
                             input bit flip, input string tag);
        int k = 0;
        int idx;
        int t [4];
        logic [31:0] d [4];
        logic l [4];
        for (int w = 0; w < 4; w++) begin
            t[w] = 0; d[w] = '0; l[w] = 1'b0;
        end
        idx = int'(a[7:4]);
        @(negedge clk);
        chk(req_ready == 1'b1, {"R6 idle before request ", tag}, req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        mode_seq  = m;
        @(posedge clk);
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_valid = poke;
                req_addr  = a ^ 32'h0000_0050;
                if (flip) mode_seq = ~m;
            end
            if (n == 5 && poke) begin
                chk(req_ready == 1'b0, {"R6 busy ready low ", tag}, req_ready, 0);
                req_valid = 1'b0;
            end
            if (rd_valid && k < 4) begin
                t[k] = n; d[k] = rd_data; l[k] = rd_last; k++;
            end
            if (rd_last) break;
        end
        chk(k == 4, {"R2 R3 word count ", tag}, k, 4);
        for (int w = 0; w < 4; w++) begin
            int et;
            et = 2 + ACC + w * (m ? ACC : 1);
            chk(t[w] == et, {(m ? "R3 word timing " : "R2 word timing "), tag}, t[w], et);
            chk(d[w] == shadow[w][idx], {"R4 word order/data ", tag}, d[w], shadow[w][idx]);
            chk(l[w] == (w == 3), {"R5 done flag ", tag}, l[w], (w == 3));
        end
        @(negedge clk);
        chk(refill_cycles == (m ? 16'd102 : 16'd30), {"R7 refill length ", tag},
            refill_cycles, (m ? 102 : 30));
        chk(req_ready == 1'b1, {"R6 ready after done ", tag}, req_ready, 1);
        mode_seq = m;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
        chk(rd_last == 1'b0, "R1 last", rd_last, 0);
        chk(refill_cycles == 16'd0, "R1 cycles", refill_cycles, 0);

        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 16; i++) begin
                load_word(b, i, pat(b, i));
            end
        end
        @(negedge clk);
        load_en = 1'b0;

        for (int v = 0; v < NV; v++) begin
            do_refill(VEC[v][31:0], VEC[v][32], 1'b0, 1'b0, "table");
        end

        // R6: a second request held during the refill is not taken
        do_refill(32'h0000_0020, 1'b0, 1'b1, 1'b0, "R6 poke");
        @(negedge clk);
        chk(rd_valid == 1'b0, "R6 no extra refill", rd_valid, 0);

        // R8: mode flipped during a refill
        do_refill(32'h0000_0040, 1'b1, 1'b0, 1'b1, "R8 flip seq");
        do_refill(32'h0000_0090, 1'b0, 1'b0, 1'b1, "R8 flip interleaved");

        // R9: overwrite one word and refill its line
        load_word(2, 3, 32'hFEED_0203);
        @(negedge clk);
        load_en = 1'b0;
        do_refill(32'h0000_0034, 1'b0, 1'b0, 1'b0, "R9 reload");
        do_refill(32'h0000_0038, 1'b1, 1'b0, 1'b0, "R9 reload seq");

        finished = 1'b1;
        report();
    end

endmodule